// File: doc/BRIEF.md
# Floating-point control register access unit

This unit serves the control-register move operations of a scalar core's floating-point coprocessor. A single strobe carries one access: a read that returns a control register, or a write that updates one. The registers it covers are the implementation word (index 0), the condition-code view of the floating-point status word (index 25), and two user-mode aliases of the status-register FR mode bit. Index 1 reads the mode bit or clears it. Index 4 sets it. Accesses that break the alias rules raise a reserved-instruction exception pulse.

The aliases depend on two configuration inputs: a presence flag inside the implementation word and a separate enable input. An alias write acts only when its general-register source index is zero. Otherwise it does nothing and raises nothing. The status word is held inside the unit, and software sees it only through the index-25 view. The FR bit is held inside the unit and driven out to the core.

Top module: `fpctl_access`

## Requirements
- R1: A read of index 0 returns the 32-bit implementation word, sign-extended to DW bits, on `rd_data` one cycle after the strobe.
- R2: A read of index 1, when the presence flag (implementation word bit PRESENT_POS, default 28) is 1 and `alias_en` is 1, returns the FR bit in bit 0 with zeros above it.
- R3: A read of index 1 with the presence flag at 1 and `alias_en` at 0 pulses `exc_ri` in the strobe cycle and returns zero.
- R4: A read of index 1 with the presence flag at 0 returns zero and leaves `exc_ri` low.
- R5: A write to index 1 clears FR and a write to index 4 sets FR. This applies when the presence flag is 1, the source index is 0 and `alias_en` is 1. The new value appears on `mode_fr` one cycle after the strobe.
- R6: A write to index 1 or 4 with the presence flag at 0, or with a nonzero source index, leaves FR unchanged and raises no exception.
- R7: A write to index 1 or 4 that passes the presence and source checks while `alias_en` is 0 leaves FR unchanged and pulses `exc_ri` in the strobe cycle.
- R8: A read of index 25 returns status bits 31:25 in `rd_data` bits 7:1 and status bit 23 in bit 0, with all higher bits zero.
- R9: A write to index 25 whose data has any bit above bit 7 set changes nothing.
- R10: A write to index 25 with data below 256 places data bits 7:1 into status bits 31:25 and data bit 0 into status bit 23. A later read of index 25 returns that data.
- R11: A read of any other index, including 4, returns zero. `exc_ri` is low whenever no strobe is present. `rd_data` changes only on reads.
- R12: After reset, `mode_fr` equals FR_RESET (default 0), `rd_data` is zero, the status word is zero and `exc_ri` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_index | input | 5 | Control register index |
| acc_src | input | 5 | General-register source index of a write |
| acc_wdata | input | DW | Write data |
| impl_word | input | 32 | Implementation word, holds the alias presence flag |
| alias_en | input | 1 | Enable for the user-mode FR aliases |
| rd_data | output | DW | Registered read result |
| exc_ri | output | 1 | Reserved-instruction exception pulse |
| mode_fr | output | 1 | Registered FR mode bit |

## Verification
The exception is combinational, so the bench samples `exc_ri` one nanosecond after it drives the strobe, within the same cycle. Read data and the FR bit each pass through one register. The bench samples them at the falling edge after the next rising edge, which is where the reference model's updated values apply. Every access produces all three comparisons, and every idle cycle confirms that the exception line stays low.

// File: rtl/fpctl_pkg.sv
package fpctl_pkg;

    localparam int IDX_W = 5;

    localparam logic [IDX_W-1:0] IDX_IMPL   = 5'd0;
    localparam logic [IDX_W-1:0] IDX_FR_CLR = 5'd1;
    localparam logic [IDX_W-1:0] IDX_FR_SET = 5'd4;
    localparam logic [IDX_W-1:0] IDX_CC     = 5'd25;

    typedef enum logic [2:0] {
        K_IMPL,
        K_FR_CLR,
        K_FR_SET,
        K_CC,
        K_OTHER
    } reg_kind_e;

    typedef enum logic [1:0] {
        FR_KEEP,
        FR_CLEAR,
        FR_SET
    } fr_op_e;

    typedef struct packed {
        logic             valid;
        logic             write;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] src;
    } acc_ctl_t;

    typedef struct packed {
        reg_kind_e kind;
        fr_op_e    fr_op;
        logic      raise_ri;
        logic      cc_wr;
        logic      rd_load;
    } acc_plan_t;

    function automatic reg_kind_e classify(logic [IDX_W-1:0] idx);
        reg_kind_e k;
        case (idx)
            IDX_IMPL:   k = K_IMPL;
            IDX_FR_CLR: k = K_FR_CLR;
            IDX_FR_SET: k = K_FR_SET;
            IDX_CC:     k = K_CC;
            default:    k = K_OTHER;
        endcase
        return k;
    endfunction

    function automatic logic [7:0] cc_pack(logic [31:0] st);
        return {st[31:25], st[23]};
    endfunction

    function automatic logic [31:0] cc_merge(logic [31:0] st, logic [7:0] v);
        logic [31:0] r;
        r        = st;
        r[31:25] = v[7:1];
        r[23]    = v[0];
        return r;
    endfunction

endpackage

// File: rtl/fpctl_decode.sv
module fpctl_decode
    import fpctl_pkg::*;
(
    input  acc_ctl_t  ctl,
    input  logic      data_hi_nz,
    input  logic      present,
    input  logic      enable,
    output acc_plan_t plan
);

    logic rd_hit;
    logic wr_hit;
    logic alias_gate;

    assign rd_hit     = ctl.valid && !ctl.write;
    assign wr_hit     = ctl.valid &&  ctl.write;
    assign alias_gate = present && (ctl.src == '0);

    always_comb begin
        plan          = '0;
        plan.kind     = classify(ctl.idx);
        plan.fr_op    = FR_KEEP;
        plan.rd_load  = rd_hit;
        unique case (plan.kind)
            K_FR_CLR: begin
                if (wr_hit && alias_gate) begin
                    if (enable) plan.fr_op    = FR_CLEAR;
                    else        plan.raise_ri = 1'b1;
                end
                if (rd_hit && present && !enable) plan.raise_ri = 1'b1;
            end
            K_FR_SET: begin
                if (wr_hit && alias_gate) begin
                    if (enable) plan.fr_op    = FR_SET;
                    else        plan.raise_ri = 1'b1;
                end
            end
            K_CC: begin
                plan.cc_wr = wr_hit && !data_hi_nz;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fpctl_fr_reg.sv
module fpctl_fr_reg
    import fpctl_pkg::*;
#(
    parameter logic FR_RESET = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  fr_op_e op,
    output logic   fr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fr <= FR_RESET;
        end else begin
            unique case (op)
                FR_CLEAR: fr <= 1'b0;
                FR_SET:   fr <= 1'b1;
                default:  fr <= fr;
            endcase
        end
    end

    AST_FR_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (op == FR_SET) |=> fr) else $error("fr set lost"); // R5
    AST_FR_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (op == FR_CLEAR) |=> !fr) else $error("fr clear lost"); // R5
    AST_FR_KEEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (op == FR_KEEP) |=> $stable(fr)) else $error("fr moved"); // R6

endmodule

// File: rtl/fpctl_status_reg.sv
module fpctl_status_reg
    import fpctl_pkg::*;
#(
    parameter logic [31:0] ST_RESET = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_val,
    output logic [31:0] st
);

    always_ff @(posedge clk) begin
        if (rst)        st <= ST_RESET;
        else if (wr_en) st <= cc_merge(st, wr_val);
    end

    AST_CC_STORE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cc_pack(st) == $past(wr_val))) else $error("cc store"); // R10
    AST_CC_KEEP: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(st)) else $error("status moved"); // R9

endmodule

// File: rtl/fpctl_access.sv
module fpctl_access
    import fpctl_pkg::*;
#(
    parameter int   DW          = 64,
    parameter int   PRESENT_POS = 28,
    parameter logic FR_RESET    = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [4:0]    acc_index,
    input  logic [4:0]    acc_src,
    input  logic [DW-1:0] acc_wdata,
    input  logic [31:0]   impl_word,
    input  logic          alias_en,
    output logic [DW-1:0] rd_data,
    output logic          exc_ri,
    output logic          mode_fr
);

    localparam int CC_W = 8;

    acc_ctl_t    ctl;
    acc_plan_t   plan;
    logic        present;
    logic        hi_nz;
    logic [31:0] status;
    logic [DW-1:0] impl_ext;
    logic [DW-1:0] rd_next;

    assign ctl     = '{valid: acc_valid, write: acc_write, idx: acc_index, src: acc_src};
    assign present = impl_word[PRESENT_POS];
    assign hi_nz   = |acc_wdata[DW-1:CC_W];

    generate
        if (DW > 32) begin : g_wide
            assign impl_ext = {{(DW-32){impl_word[31]}}, impl_word};
        end else begin : g_narrow
            assign impl_ext = impl_word[DW-1:0];
        end
    endgenerate

    fpctl_decode u_decode (
        .ctl        (ctl),
        .data_hi_nz (hi_nz),
        .present    (present),
        .enable     (alias_en),
        .plan       (plan)
    );

    fpctl_fr_reg #(.FR_RESET(FR_RESET)) u_fr (
        .clk (clk),
        .rst (rst),
        .op  (plan.fr_op),
        .fr  (mode_fr)
    );

    fpctl_status_reg u_status (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (plan.cc_wr),
        .wr_val (acc_wdata[CC_W-1:0]),
        .st     (status)
    );

    always_comb begin
        rd_next = '0;
        unique case (plan.kind)
            K_IMPL:   rd_next = impl_ext;
            K_FR_CLR: rd_next[0] = present && alias_en && mode_fr;
            K_CC:     rd_next[CC_W-1:0] = cc_pack(status);
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)               rd_data <= '0;
        else if (plan.rd_load) rd_data <= rd_next;
    end

    assign exc_ri = plan.raise_ri;

    AST_EXC_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        exc_ri |-> acc_valid) else $error("exc without strobe"); // R11
    AST_EXC_FR_HOLD: assert property (@(posedge clk) disable iff (rst)
        exc_ri |=> $stable(mode_fr)) else $error("fr moved on exc"); // R7
    AST_CC_READ_NARROW: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_index == IDX_CC) |=> (rd_data[DW-1:CC_W] == '0))
        else $error("cc read wide"); // R8
    AST_BAD_CC_WRITE: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_index == IDX_CC && hi_nz) |=> $stable(status))
        else $error("bad cc write took"); // R9
    AST_UNUSED_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_index != IDX_IMPL && acc_index != IDX_FR_CLR
         && acc_index != IDX_CC) |=> (rd_data == '0)) else $error("unused idx"); // R11
    AST_WRITE_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write) |=> $stable(rd_data)) else $error("rd moved on write"); // R11

endmodule

// File: tb/test_fpctl_access.sv
`timescale 1ns/1ps
module test_fpctl_access;

    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic          acc_valid;
    logic          acc_write;
    logic [4:0]    acc_index;
    logic [4:0]    acc_src;
    logic [DW-1:0] acc_wdata;
    logic [31:0]   impl_word;
    logic          alias_en;
    logic [DW-1:0] rd_data;
    logic          exc_ri;
    logic          mode_fr;

    integer n_checks = 0;
    integer n_errors = 0;
    logic   done = 1'b0;

    logic          m_fr;
    logic [31:0]   m_st;
    logic [DW-1:0] m_rd;
    logic          m_exc;

    always #2.5 clk = ~clk;

    fpctl_access i_fpctl_access (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_index(acc_index), .acc_src(acc_src), .acc_wdata(acc_wdata),
        .impl_word(impl_word), .alias_en(alias_en), .rd_data(rd_data),
        .exc_ri(exc_ri), .mode_fr(mode_fr)
    );

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input string req, input bit wr, input int idx,
                          input int src, input logic [DW-1:0] data);
        logic present;
        present   = impl_word[28];
        acc_valid = 1'b1;
        acc_write = wr;
        acc_index = 5'(idx);
        acc_src   = 5'(src);
        acc_wdata = data;
        m_exc     = 1'b0;
        if (!wr) begin
            if (idx == 0)       m_rd = {{32{impl_word[31]}}, impl_word};
            else if (idx == 25) m_rd = {56'h0, m_st[31:25], m_st[23]};
            else if (idx == 1) begin
                m_rd = '0;
                if (present && alias_en)  m_rd[0] = m_fr;
                if (present && !alias_en) m_exc = 1'b1;
            end else m_rd = '0;
        end else begin
            if ((idx == 1 || idx == 4) && present && src == 0) begin
                if (alias_en) m_fr = (idx == 4);
                else          m_exc = 1'b1;
            end
            if (idx == 25 && data < 256) begin
                m_st[31:25] = data[7:1];
                m_st[23]    = data[0];
            end
        end
        #1;
        check(req, "exc_ri", DW'(exc_ri), DW'(m_exc));
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        check(req, "rd_data", rd_data, m_rd);
        check(req, "mode_fr", DW'(mode_fr), DW'(m_fr));
    endtask

    task automatic idle_check();
        #1;
        check("R11", "idle exc_ri", DW'(exc_ri), '0);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; acc_valid = 0; acc_write = 0; acc_index = 0; acc_src = 0;
        acc_wdata = '0; impl_word = 32'h9000_0A55; alias_en = 1'b1;
        m_fr = 1'b0; m_st = '0; m_rd = '0; m_exc = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        check("R12", "rd_data", rd_data, '0);
        check("R12", "mode_fr", DW'(mode_fr), '0);
        check("R12", "exc_ri", DW'(exc_ri), '0);
        access("R12", 0, 25, 0, '0);
        // R1 sign-extension both ways
        access("R1", 0, 0, 0, '0);
        impl_word = 32'h1000_1234;
        access("R1", 0, 0, 0, '0);
        idle_check();
        // R2 read the FR bit at 0, then R5 set it
        access("R2", 0, 1, 0, '0);
        access("R5", 1, 4, 0, '0);
        access("R2", 0, 1, 0, '0);
        // R6 nonzero source index ignored
        access("R6", 1, 1, 3, '0);
        access("R6", 1, 4, 31, '0);
        // R6 and R4 with the presence flag clear
        impl_word = 32'h0000_1234;
        access("R6", 1, 1, 0, '0);
        access("R4", 0, 1, 0, '0);
        impl_word = 32'h1000_1234;
        // R3 and R7 with the enable clear
        alias_en = 1'b0;
        access("R3", 0, 1, 0, '0);
        access("R7", 1, 1, 0, '0);
        access("R7", 1, 4, 0, '0);
        access("R6", 1, 1, 2, '0);
        idle_check();
        alias_en = 1'b1;
        // R5 clear then set again
        access("R5", 1, 1, 0, '0);
        access("R2", 0, 1, 0, '0);
        access("R5", 1, 4, 0, 64'hFFFF);
        // R10 and R8 condition-code writes and reads
        access("R10", 1, 25, 0, 64'hA5);
        access("R8", 0, 25, 0, '0);
        access("R9", 1, 25, 0, 64'h1FF);
        access("R9", 0, 25, 0, '0);
        access("R9", 1, 25, 0, 64'h8000_0000_0000_0003);
        access("R10", 1, 25, 7, 64'h5A);
        access("R8", 0, 25, 0, '0);
        access("R10", 1, 25, 0, 64'hFF);
        access("R8", 0, 25, 0, '0);
        // R11 other indices read zero
        access("R11", 0, 4, 0, '0);
        access("R11", 0, 7, 0, '0);
        access("R11", 0, 31, 0, '0);
        access("R11", 1, 9, 0, 64'h1);
        idle_check();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule